// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing slave of a 256-byte non-volatile store, modelled with a register array so that it can run in simulation. The system clock oversamples the serial clock and data lines. The open-drain data line appears as two signals: a data-in line that carries the resolved bus level, and an output enable that pulls the bus low when it is asserted. The slave watches for bus start and stop conditions and answers its own 7-bit device address. It accepts an 8-bit word address and then performs one of four operations: a single-byte write, a read at the current pointer, a read at a given address, or a read that streams bytes at rising addresses.

A write is held pending until the master ends the command with a STOP. The write-protect input is sampled at that STOP, so the master can still cancel an accepted byte at that point. A busy counter stands in for the internal programming time. For that many system clocks the slave does not acknowledge its device address, and the master can poll it to learn when the write has finished. One internal pointer serves both the word-address phase and every read, so a later command can pick up where an earlier read stopped.

Top module: `tws_eeprom`

## Requirements
- R1: After reset the output enable is low, no programming cycle is running, and the first correct device address is acknowledged.
- R2: The first byte after a START is taken MSB first. Bits [7:1] are the device address (parameter DEV_ADDR, default 7'h50) and bit 0 selects the direction (0 = write, 1 = read). A byte with any other address gets no acknowledge, and the slave keeps SDA released until the next START.
- R3: A byte write is a device byte with bit 0 = 0, then a word address, then one data byte, each acknowledged, and then a STOP. It stores the data at that word address. Only a STOP directly after the data byte commits the write. A further data byte in the same command is not acknowledged.
- R4: The write-protect input is sampled at the STOP that would commit a write. If it is high there, the memory is unchanged and no busy period starts. Its level during the bytes has no effect.
- R5: After a committed write, the device address is not acknowledged for BUSY_CYC system clocks (default 300). After that it is acknowledged again.
- R6: A random read is a device byte with bit 0 = 0 and a word address, then a repeated START and a device byte with bit 0 = 1. It returns the byte at that address, MSB first. The slave changes SDA only while SCL is low.
- R7: Each master acknowledge after a read byte makes the slave send the next byte. The address goes up by one and wraps from 255 to 0.
- R8: A current read returns the byte at the internal pointer. The word-address phase loads the pointer, each byte sent raises it by one, and a write leaves it on the written address.
- R9: After a master NACK on a read byte, the slave drives no bit until the next START. A STOP then ends the command, and the output enable is low on the clock after the STOP is detected.
- R10: A START or STOP in the middle of a byte aborts the command. An aborted write changes no memory and starts no busy period, and a new command after an abort is served normally.
- R11: The output enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Resolved level of the serial data line |
| wp_i | input | 1 | Write protect, sampled at the committing STOP |
| sda_oe_o | output | 1 | When high, the slave pulls the data line low |

## Verification
The hardest states to reach are the narrow windows around a commit: write-protect changing between the data byte and the STOP, a START that replaces the STOP after the data acknowledge, and the busy window seen from the bus. The bench reaches them with directed sequences. It raises write protect only across the STOP, or only across the bytes. It aborts commands with a START or STOP after a partial byte. It re-addresses the device at once after a commit, so that the not-acknowledge arrives well inside the busy count, and it addresses the device again after the count has run out. Seeded random writes and reads then cover the pointer and its wrap.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN,
    ST_WAIT
  } tws_state_e;
endpackage

// File: rtl/tws_bus_sync.sv
module tws_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_mem_array.sv
module tws_mem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR = 7'h50,
  parameter int               AW       = 8,
  parameter int               BUSY_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              sda_oe,
  output logic              busy_o
);
  localparam int BW  = $clog2(BUSY_CYC + 1);
  localparam int BCW = $clog2(BYTE_W + 1);

  tws_state_e        state_q, state_d;
  tws_state_e        after_q, after_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              pend_q, pend_d;
  logic              mack_q, mack_d;
  logic [BW-1:0]     busy_q, busy_d;

  logic byte_full;
  logic dev_hit;

  assign byte_full = (bcnt_q == BCW'(BYTE_W));
  assign dev_hit   = (sh_q[BYTE_W-1:1] == DEV_ADDR) && (busy_q == '0);

  always_comb begin
    state_d = state_q;
    after_d = after_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    pend_d  = pend_q;
    mack_d  = mack_q;
    busy_d  = busy_q;
    mem_we  = 1'b0;

    if (busy_q != '0) begin
      busy_d = busy_q - BW'(1);
    end

    if (start_det) begin
      state_d = ST_DEV;
      bcnt_d  = '0;
      pend_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      if (pend_q && !wp_i) begin
        mem_we = 1'b1;
        busy_d = BW'(BUSY_CYC);
      end
    end else begin
      case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && !byte_full) begin
            sh_d   = {sh_q[BYTE_W-2:0], sda_s};
            bcnt_d = bcnt_q + BCW'(1);
          end else if (scl_fall && byte_full) begin
            bcnt_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                state_d = ST_ACK_OUT;
                after_d = sh_q[0] ? ST_TX : ST_WADR;
              end else begin
                state_d = ST_WAIT;
              end
            end else if (state_q == ST_WADR) begin
              addr_d  = sh_q[AW-1:0];
              state_d = ST_ACK_OUT;
              after_d = ST_WDAT;
            end else begin
              wdat_d  = sh_q;
              pend_d  = 1'b1;
              state_d = ST_ACK_OUT;
              after_d = ST_WAIT;
            end
          end
        end
        ST_ACK_OUT: begin
          if (scl_fall) begin
            bcnt_d = '0;
            if (after_q == ST_TX) begin
              sh_d    = rdata;
              addr_d  = addr_q + AW'(1);
              state_d = ST_TX;
            end else begin
              state_d = after_q;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt_q == BCW'(BYTE_W - 1)) begin
              state_d = ST_ACK_IN;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b1};
              bcnt_d = bcnt_q + BCW'(1);
            end
          end
        end
        ST_ACK_IN: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rdata;
              addr_d  = addr_q + AW'(1);
              bcnt_d  = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      bcnt_q  <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      pend_q  <= 1'b0;
      mack_q  <= 1'b0;
      busy_q  <= '0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      pend_q  <= pend_d;
      mack_q  <= mack_d;
      busy_q  <= busy_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign busy_o    = (busy_q != '0);
  assign sda_oe    = (state_q == ST_ACK_OUT) ||
                     ((state_q == ST_TX) && !sh_q[BYTE_W-1]);
endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom
  import tws_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR    = 7'h50,
  parameter int               AW          = 8,
  parameter int               BUSY_CYC    = 300,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic              busy;
  logic [AW-1:0]     mem_addr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;

  tws_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .AW       (AW),
    .BUSY_CYC (BUSY_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .wp_i      (wp_i),
    .rdata     (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe_o),
    .busy_o    (busy)
  );

  tws_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/tws_eeprom_chk.sv
module tws_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic mem_we,
  input logic busy,
  input logic sda_oe
);
  AST_OE_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R11

  AST_WRITE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> stop_det); // R3

  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy); // R5

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mem_we)); // R5

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9
endmodule

bind tws_eeprom tws_eeprom_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .mem_we   (mem_we),
  .busy     (busy),
  .sda_oe   (sda_oe_o)
);

// File: tb/tws_eeprom_bench.sv
module tws_eeprom_bench;
  localparam int H    = 10;
  localparam int BUSY = 300;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [7:0] DW_BYTE = {DEV, 1'b0};
  localparam logic [7:0] DR_BYTE = {DEV, 1'b1};

  logic clk;
  logic rst_n;
  logic m_scl;
  logic m_sda;
  logic wp;
  wire  sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  tws_eeprom #(.DEV_ADDR(DEV), .BUSY_CYC(BUSY)) u_tws_eeprom (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] exp_mem [256];
  bit         written [256];
  logic [7:0] exp_ptr;
  int         n_vec;
  int         n_err;
  bit         done;

  function automatic logic [7:0] exp_at(input logic [7:0] a);
    return exp_mem[a];
  endfunction

  function automatic logic [7:0] ptr_after(input logic [7:0] a, input int n);
    return a + 8'(n);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H/2);
    b = sda_bus;  tick(H/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    put_bit(!mack);
  endtask

  task automatic probe(output bit ack);
    bus_start();
    send_byte(DW_BYTE, ack);
    bus_stop();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic wpv);
    bit ack;
    bus_start();
    send_byte(DW_BYTE, ack); chk("R3 dev ack", int'(ack), 1);
    send_byte(a, ack);       chk("R3 addr ack", int'(ack), 1);
    exp_ptr = a;
    send_byte(d, ack);       chk("R3 data ack", int'(ack), 1);
    wp = wpv;
    bus_stop();
    wp = 1'b0;
    if (!wpv) begin
      exp_mem[a] = d;
      written[a] = 1'b1;
      tick(BUSY + 10);
    end
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    bit ack;
    bus_start();
    send_byte(DW_BYTE, ack); chk("R6 dev ack", int'(ack), 1);
    send_byte(a, ack);       chk("R6 addr ack", int'(ack), 1);
    bus_start();
    send_byte(DR_BYTE, ack); chk("R6 read ack", int'(ack), 1);
    recv_byte(d, 1'b0);
    bus_stop();
    exp_ptr = ptr_after(a, 1);
  endtask

  task automatic cur_read(output logic [7:0] d);
    bit ack;
    bus_start();
    send_byte(DR_BYTE, ack); chk("R8 read ack", int'(ack), 1);
    recv_byte(d, 1'b0);
    bus_stop();
    exp_ptr = ptr_after(exp_ptr, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    bit         ack;
    logic [7:0] d;
    logic [7:0] a;
    logic [7:0] v;
    n_vec = 0; n_err = 0; done = 1'b0;
    void'($urandom(32'h5EED));
    m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; exp_ptr = '0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: idle after reset
    chk("R1 oe after reset", int'(sda_oe), 0);
    probe(ack);
    chk("R1 first address ack", int'(ack), 1);

    // R2: foreign addresses get no ack and SDA stays released
    bus_start();
    send_byte({7'h51, 1'b0}, ack); chk("R2 foreign 51 nack", int'(ack), 0);
    recv_byte(v, 1'b0);            chk("R2 released after foreign", int'(v), 8'hFF);
    bus_stop();
    bus_start();
    send_byte({7'h10, 1'b1}, ack); chk("R2 foreign 10 nack", int'(ack), 0);
    bus_stop();

    // R3: writes around the top of the address space and a few more
    for (int i = 0; i < 12; i++) begin
      a = 8'(250 + i);
      do_write(a, 8'($urandom), 1'b0);
    end
    do_write(8'h80, 8'h00, 1'b0);
    do_write(8'h81, 8'hFF, 1'b0);

    // R6: random reads
    rand_read(8'h80, d); chk("R6 read 80", int'(d), int'(exp_at(8'h80)));
    rand_read(8'h81, d); chk("R6 read 81", int'(d), int'(exp_at(8'h81)));
    rand_read(8'hFB, d); chk("R6 read FB", int'(d), int'(exp_at(8'hFB)));

    // R8: current read follows the last read
    rand_read(8'hFA, d); chk("R6 read FA", int'(d), int'(exp_at(8'hFA)));
    cur_read(d);         chk("R8 current after read", int'(d), int'(exp_at(8'hFB)));
    cur_read(d);         chk("R8 second current", int'(d), int'(exp_at(8'hFC)));

    // R8: a write leaves the pointer on the written address
    do_write(8'h40, 8'h3C, 1'b0);
    cur_read(d);         chk("R8 current after write", int'(d), 8'h3C);

    // R7: sequential read wrapping 255 -> 0
    bus_start();
    send_byte(DW_BYTE, ack); chk("R7 dev ack", int'(ack), 1);
    send_byte(8'hFA, ack);   chk("R7 addr ack", int'(ack), 1);
    bus_start();
    send_byte(DR_BYTE, ack); chk("R7 read ack", int'(ack), 1);
    for (int i = 0; i < 12; i++) begin
      recv_byte(d, i != 11);
      chk("R7 sequential byte", int'(d), int'(exp_at(8'(250 + i))));
    end
    // R9: after the NACK, no bit is driven before STOP
    recv_byte(v, 1'b0);
    chk("R9 released after nack", int'(v), 8'hFF);
    bus_stop();
    tick(2);
    chk("R9 oe low after stop", int'(sda_oe), 0);
    exp_ptr = 8'd6;

    // R5: busy window after a commit
    do_write(8'h90, 8'h5A, 1'b0);
    bus_start();
    send_byte(DW_BYTE, ack); chk("R3 dev ack", int'(ack), 1);
    send_byte(8'h91, ack);   chk("R3 addr ack", int'(ack), 1);
    send_byte(8'hA5, ack);   chk("R3 data ack", int'(ack), 1);
    bus_stop();
    exp_mem[8'h91] = 8'hA5; written[8'h91] = 1'b1;
    probe(ack);              chk("R5 nack while busy", int'(ack), 0);
    tick(BUSY);
    probe(ack);              chk("R5 ack after busy", int'(ack), 1);
    rand_read(8'h91, d);     chk("R5 busy write stored", int'(d), 8'hA5);

    // R3: second data byte in one command is refused
    bus_start();
    send_byte(DW_BYTE, ack);
    send_byte(8'h92, ack);
    send_byte(8'h11, ack);   chk("R3 first data ack", int'(ack), 1);
    send_byte(8'h22, ack);   chk("R3 second data nack", int'(ack), 0);
    bus_stop();
    exp_mem[8'h92] = 8'h11; written[8'h92] = 1'b1;
    tick(BUSY + 10);
    rand_read(8'h92, d);     chk("R3 single byte stored", int'(d), 8'h11);

    // R3: repeated START instead of STOP drops the pending write
    bus_start();
    send_byte(DW_BYTE, ack);
    send_byte(8'h80, ack);
    send_byte(8'h77, ack);
    bus_start();
    send_byte(DW_BYTE, ack); chk("R3 no commit without stop", int'(ack), 1);
    bus_stop();
    rand_read(8'h80, d);     chk("R3 unchanged after restart", int'(d), int'(exp_at(8'h80)));

    // R4: write protect high at STOP cancels the write
    do_write(8'h81, 8'h12, 1'b1);
    probe(ack);              chk("R4 no busy when protected", int'(ack), 1);
    rand_read(8'h81, d);     chk("R4 memory unchanged", int'(d), int'(exp_at(8'h81)));

    // R4: write protect high only during bytes has no effect
    wp = 1'b1;
    bus_start();
    send_byte(DW_BYTE, ack);
    send_byte(8'h81, ack);
    send_byte(8'h34, ack);
    wp = 1'b0;
    bus_stop();
    exp_mem[8'h81] = 8'h34;
    tick(BUSY + 10);
    rand_read(8'h81, d);     chk("R4 write with wp low at stop", int'(d), 8'h34);

    // R10: STOP in the middle of the data byte
    bus_start();
    send_byte(DW_BYTE, ack);
    send_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    probe(ack);              chk("R10 no busy after abort", int'(ack), 1);
    rand_read(8'h40, d);     chk("R10 memory kept", int'(d), 8'h3C);

    // R10: START in the middle of the word address
    bus_start();
    send_byte(DW_BYTE, ack);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_start();
    send_byte(DW_BYTE, ack); chk("R10 dev ack after abort", int'(ack), 1);
    send_byte(8'h41, ack);   chk("R10 addr ack after abort", int'(ack), 1);
    send_byte(8'hC3, ack);   chk("R10 data ack after abort", int'(ack), 1);
    bus_stop();
    exp_mem[8'h41] = 8'hC3; written[8'h41] = 1'b1;
    tick(BUSY + 10);
    rand_read(8'h41, d);     chk("R10 write after abort", int'(d), 8'hC3);

    // Seeded random mix of writes and reads
    for (int k = 0; k < 24; k++) begin
      a = 8'($urandom);
      if (written[a] && ($urandom % 2 == 0)) begin
        rand_read(a, d);
        chk("R6 random read", int'(d), int'(exp_at(a)));
        if (written[exp_ptr]) begin
          v = exp_at(exp_ptr);
          cur_read(d);
          chk("R8 random current read", int'(d), int'(v));
        end
      end else begin
        do_write(a, 8'($urandom), 1'b0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule